// File: doc/BRIEF.md
# Signed-word pair load unit

This unit carries out one "load two signed words" instruction at a time. A caller presents a 32-bit instruction word with a one-cycle `start` strobe. The unit decodes one of three addressing forms: a plain signed offset, pre-update and post-update. It takes the base either from a register-file read port or, for base index 31, from the stack-pointer input. It then forms the access address from a scaled signed 7-bit immediate.

Two 32-bit reads go out one after the other over a request/valid memory port. Each returned word is widened to 64 bits by copying its sign bit. Both results are written to the two target registers in the same cycle. The updating forms also hand the new base value to a writeback port, which is steered to the stack pointer when the base index is 31. Condition flags are never touched.

Encodings the unit does not support, a misaligned stack pointer and register overlaps with no defined result all end the operation with a flag. In each of these cases no memory read and no register write takes place. Every operation, faulted or not, ends with a one-cycle `done` pulse, and the flags are reported during that pulse.

Top module: `ldpw_exec_unit`

## Requirements
- R1: An instruction is accepted only when bits 31:30 = 01, bits 29:27 = 101, bit 26 = 0, bit 22 = 1, and bits 25:23 are 001 (post-update), 011 (pre-update) or 010 (signed offset). Any other word makes `unsupported` high during `done`, with no read and no write.
- R2: The fields are: immediate in bits 21:15, second target in bits 14:10, base index in bits 9:5 and first target in bits 4:0. The byte offset is the immediate sign-extended and multiplied by 4, which spans -256 to +252.
- R3: Base index 31 takes the base from `sp_in`. Any other index takes it from `rf_rd_data`, which is read at `rf_rd_idx` = bits 9:5 of `instr`.
- R4: The first read address is base + offset in the signed-offset and pre-update forms. In the post-update form it is the base unchanged.
- R5: The first read goes out at the first address and the second read at that address + 4. `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is sampled high.
- R6: Both targets are written in one cycle, one cycle after the second `mem_rvalid`. The first word goes to the first target and the second word to the second target, each with bit 31 copied into bits 63:32.
- R7: The pre-update and post-update forms assert `wb_en` with `wb_data` = base + offset in the same cycle as the target writes. `wb_to_sp` is high when the base index is 31. The signed-offset form never asserts `wb_en`.
- R8: When the base index is 31 and bits 3:0 of `sp_in` are not zero, `misaligned` is high during `done` and no read or write happens. An unsupported word takes precedence over this flag.
- R9: If the two targets are equal, `unpredictable` is high during `done` and no read or write happens. The same applies in the updating forms when either target equals a base index other than 31. The signed-offset form allows a target to equal the base.
- R10: `done` is a one-cycle pulse that ends every accepted `start`. A faulted operation raises `done` in the cycle right after `start`. `busy` is high from that cycle until `done` ends.
- R11: After reset, all request, write, done, busy and flag outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins an operation on `instr` (sampled while idle) |
| instr | input | 32 | Instruction word |
| sp_in | input | 64 | Current stack pointer |
| rf_rd_idx | output | 5 | Register-file read index (base field) |
| rf_rd_data | input | 64 | Register-file read data |
| mem_req | output | 1 | Read request, held until `mem_rvalid` |
| mem_addr | output | 64 | Read byte address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data word |
| wr1_en | output | 1 | First target write enable |
| wr1_idx | output | 5 | First target index |
| wr1_data | output | 64 | First target data |
| wr2_en | output | 1 | Second target write enable |
| wr2_idx | output | 5 | Second target index |
| wr2_data | output | 64 | Second target data |
| wb_en | output | 1 | Base writeback enable |
| wb_to_sp | output | 1 | Writeback targets the stack pointer |
| wb_idx | output | 5 | Base writeback index |
| wb_data | output | 64 | Updated base value |
| done | output | 1 | End-of-operation pulse |
| busy | output | 1 | Operation in progress |
| unsupported | output | 1 | Encoding rejected (valid with `done`) |
| misaligned | output | 1 | Stack pointer misaligned (valid with `done`) |
| unpredictable | output | 1 | Register overlap rejected (valid with `done`) |

## Verification
A fault is due one cycle after the `start` edge, as `done` plus its flag. On the normal path the first request is visible in that same cycle. Each response moves the unit on at the next edge, the writes appear one cycle after the second response, and `done` follows one cycle later. The bench drives inputs and samples every output on the falling edge. It advances its own expected phase one clock at a time and varies the response latency of each read from zero to three cycles, so every due cycle is checked at the exact clock where the result should appear.

// File: rtl/ldpw_pkg.sv
package ldpw_pkg;
   localparam int unsigned REG_IDX_W = 5;
   localparam logic [REG_IDX_W-1:0] SP_INDEX = 5'd31;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RD1,
      ST_RD2,
      ST_WB,
      ST_DONE
   } ldpw_state_e;

   typedef enum logic [1:0] {
      AM_POST,
      AM_PRE,
      AM_OFFS,
      AM_BAD
   } ldpw_mode_e;

   typedef struct packed {
      logic                 legal;
      ldpw_mode_e           mode;
      logic                 wback;
      logic [6:0]           imm;
      logic [REG_IDX_W-1:0] t1;
      logic [REG_IDX_W-1:0] t2;
      logic [REG_IDX_W-1:0] n;
   } ldpw_dec_t;
endpackage

// File: rtl/ldpw_decode.sv
module ldpw_decode
   import ldpw_pkg::*;
(
   input  logic [31:0] instr,
   output ldpw_dec_t   dec
);
   logic fixed_ok;

   always_comb begin
      fixed_ok = (instr[31:30] == 2'b01) && (instr[29:27] == 3'b101)
               && !instr[26] && instr[22];
      dec = '0;
      unique case (instr[25:23])
         3'b001:  dec.mode = AM_POST;
         3'b011:  dec.mode = AM_PRE;
         3'b010:  dec.mode = AM_OFFS;
         default: dec.mode = AM_BAD;
      endcase
      dec.legal = fixed_ok && (dec.mode != AM_BAD);
      dec.wback = (dec.mode == AM_POST) || (dec.mode == AM_PRE);
      dec.imm   = instr[21:15];
      dec.t2    = instr[14:10];
      dec.n     = instr[9:5];
      dec.t1    = instr[4:0];
   end
endmodule

// File: rtl/ldpw_agen.sv
module ldpw_agen #(
   parameter int unsigned XLEN  = 64,
   parameter int unsigned IMM_W = 7,
   parameter int unsigned SCALE = 2
) (
   input  logic [XLEN-1:0]  base,
   input  logic [IMM_W-1:0] imm,
   input  logic             post,
   output logic [XLEN-1:0]  acc_addr,
   output logic [XLEN-1:0]  upd_addr
);
   localparam int unsigned OFF_W = IMM_W + SCALE;

   logic [XLEN-1:0] offset;

   generate
      if (SCALE == 0) begin : g_unscaled
         assign offset = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
      end else begin : g_scaled
         assign offset = {{(XLEN-OFF_W){imm[IMM_W-1]}}, imm, {SCALE{1'b0}}};
      end
   endgenerate

   assign upd_addr = base + offset;
   assign acc_addr = post ? base : upd_addr;

   initial begin
      assert_agen_width_R2: assert (XLEN > OFF_W)
         else $error("offset wider than address");
   end
endmodule

// File: rtl/ldpw_sext.sv
module ldpw_sext #(
   parameter int unsigned IN_W  = 32,
   parameter int unsigned OUT_W = 64,
   parameter int unsigned LANES = 2
) (
   input  logic [LANES*IN_W-1:0]  din,
   output logic [LANES*OUT_W-1:0] dout
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         if (OUT_W == IN_W) begin : g_same
            assign dout[g*OUT_W +: OUT_W] = din[g*IN_W +: IN_W];
         end else begin : g_wide
            assign dout[g*OUT_W +: OUT_W] =
               {{(OUT_W-IN_W){din[g*IN_W+IN_W-1]}}, din[g*IN_W +: IN_W]};
         end
      end
   endgenerate

   initial begin
      assert_sext_width_R6: assert (OUT_W >= IN_W)
         else $error("output narrower than input");
   end
endmodule

// File: rtl/ldpw_exec_unit.sv
module ldpw_exec_unit
   import ldpw_pkg::*;
#(
   parameter int unsigned XLEN          = 64,
   parameter int unsigned WORD_W        = 32,
   parameter int unsigned IMM_W         = 7,
   parameter int unsigned IMM_SCALE     = 2,
   parameter int unsigned SP_ALIGN_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [31:0]          instr,
   input  logic [XLEN-1:0]      sp_in,
   output logic [REG_IDX_W-1:0] rf_rd_idx,
   input  logic [XLEN-1:0]      rf_rd_data,
   output logic                 mem_req,
   output logic [XLEN-1:0]      mem_addr,
   input  logic                 mem_rvalid,
   input  logic [WORD_W-1:0]    mem_rdata,
   output logic                 wr1_en,
   output logic [REG_IDX_W-1:0] wr1_idx,
   output logic [XLEN-1:0]      wr1_data,
   output logic                 wr2_en,
   output logic [REG_IDX_W-1:0] wr2_idx,
   output logic [XLEN-1:0]      wr2_data,
   output logic                 wb_en,
   output logic                 wb_to_sp,
   output logic [REG_IDX_W-1:0] wb_idx,
   output logic [XLEN-1:0]      wb_data,
   output logic                 done,
   output logic                 busy,
   output logic                 unsupported,
   output logic                 misaligned,
   output logic                 unpredictable
);
   localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(WORD_W / 8);

   initial begin
      assert_cfg_word_R6: assert (WORD_W % 8 == 0 && XLEN >= WORD_W)
         else $error("bad word width");
      assert_cfg_imm_R2: assert (IMM_W == 7)
         else $error("immediate field is 7 bits");
      assert_cfg_align_R8: assert (SP_ALIGN_BITS < XLEN)
         else $error("alignment too large");
   end

   ldpw_dec_t   dec;
   ldpw_state_e state_q;
   logic [XLEN-1:0] base_sel, acc_addr, upd_addr;
   logic [XLEN-1:0] addr1_q, upd_q;
   logic [REG_IDX_W-1:0] t1_q, t2_q, n_q;
   logic wback_q;
   logic [WORD_W-1:0] w1_q, w2_q;
   logic uns_q, mis_q, unp_q;
   logic sp_ok, f_uns, f_mis, f_unp, f_any;
   logic [2*XLEN-1:0] ext;

   ldpw_decode u_dec (
      .instr (instr),
      .dec   (dec)
   );

   assign rf_rd_idx = dec.n;
   assign base_sel  = (dec.n == SP_INDEX) ? sp_in : rf_rd_data;

   ldpw_agen #(
      .XLEN  (XLEN),
      .IMM_W (IMM_W),
      .SCALE (IMM_SCALE)
   ) u_agen (
      .base     (base_sel),
      .imm      (dec.imm),
      .post     (dec.mode == AM_POST),
      .acc_addr (acc_addr),
      .upd_addr (upd_addr)
   );

   generate
      if (SP_ALIGN_BITS == 0) begin : g_no_align
         assign sp_ok = 1'b1;
      end else begin : g_align
         assign sp_ok = (sp_in[SP_ALIGN_BITS-1:0] == '0);
      end
   endgenerate

   always_comb begin
      f_uns = !dec.legal;
      f_mis = dec.legal && (dec.n == SP_INDEX) && !sp_ok;
      f_unp = dec.legal && !f_mis &&
              ((dec.t1 == dec.t2) ||
               (dec.wback && (dec.n != SP_INDEX) &&
                ((dec.t1 == dec.n) || (dec.t2 == dec.n))));
      f_any = f_uns || f_mis || f_unp;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         addr1_q <= '0;
         upd_q   <= '0;
         t1_q    <= '0;
         t2_q    <= '0;
         n_q     <= '0;
         wback_q <= 1'b0;
         w1_q    <= '0;
         w2_q    <= '0;
         uns_q   <= 1'b0;
         mis_q   <= 1'b0;
         unp_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  addr1_q <= acc_addr;
                  upd_q   <= upd_addr;
                  t1_q    <= dec.t1;
                  t2_q    <= dec.t2;
                  n_q     <= dec.n;
                  wback_q <= dec.wback;
                  uns_q   <= f_uns;
                  mis_q   <= f_mis;
                  unp_q   <= f_unp;
                  state_q <= f_any ? ST_DONE : ST_RD1;
               end
            end
            ST_RD1: begin
               if (mem_rvalid) begin
                  w1_q    <= mem_rdata;
                  state_q <= ST_RD2;
               end
            end
            ST_RD2: begin
               if (mem_rvalid) begin
                  w2_q    <= mem_rdata;
                  state_q <= ST_WB;
               end
            end
            ST_WB:   state_q <= ST_DONE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   ldpw_sext #(
      .IN_W  (WORD_W),
      .OUT_W (XLEN),
      .LANES (2)
   ) u_sext (
      .din  ({w2_q, w1_q}),
      .dout (ext)
   );

   always_comb begin
      mem_req       = (state_q == ST_RD1) || (state_q == ST_RD2);
      mem_addr      = (state_q == ST_RD2) ? (addr1_q + WORD_BYTES) : addr1_q;
      wr1_en        = (state_q == ST_WB);
      wr2_en        = (state_q == ST_WB);
      wr1_idx       = t1_q;
      wr2_idx       = t2_q;
      wr1_data      = ext[XLEN-1:0];
      wr2_data      = ext[2*XLEN-1:XLEN];
      wb_en         = (state_q == ST_WB) && wback_q;
      wb_to_sp      = wb_en && (n_q == SP_INDEX);
      wb_idx        = n_q;
      wb_data       = upd_q;
      done          = (state_q == ST_DONE);
      busy          = (state_q != ST_IDLE);
      unsupported   = done && uns_q;
      misaligned    = done && mis_q;
      unpredictable = done && unp_q;
   end

   assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   assert_second_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RD2 && $past(state_q) == ST_RD1)
         |-> (mem_addr == $past(mem_addr) + WORD_BYTES));

   assert_write_pair_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr1_en |-> (wr2_en && !mem_req));

   assert_write_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr1_en |=> done);

   assert_wb_with_writes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wb_en |-> wr1_en);

   assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (unsupported || misaligned || unpredictable))
         |-> ($past(state_q) == ST_IDLE));

   assert_one_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({unsupported, misaligned, unpredictable}));

   assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/ldpw_exec_unit_test.sv
module ldpw_exec_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] instr = '0;
   logic [63:0] sp_in = '0;
   logic [4:0]  rf_rd_idx;
   logic [63:0] rf_rd_data;
   logic        mem_req;
   logic [63:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        wr1_en, wr2_en, wb_en, wb_to_sp, done, busy;
   logic [4:0]  wr1_idx, wr2_idx, wb_idx;
   logic [63:0] wr1_data, wr2_data, wb_data;
   logic        unsupported, misaligned, unpredictable;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [63:0] rf_val(input logic [4:0] i);
      return 64'h0000_0040_0000_0000 + {51'd0, i, 8'h00};
   endfunction

   assign rf_rd_data = rf_val(rf_rd_idx);

   // sign bit of each word equals address bit 2: the pair always has one of each sign
   function automatic logic [31:0] mword(input logic [63:0] a);
      return {a[2], a[30:0] ^ 31'h1234_5678};
   endfunction

   function automatic logic [31:0] mk(input logic [2:0] m, input logic [6:0] imm,
                                      input logic [4:0] t2, n, t1);
      return {2'b01, 3'b101, 1'b0, m, 1'b1, imm, t2, n, t1};
   endfunction

   ldpw_exec_unit uut (
      .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .sp_in(sp_in),
      .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
      .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
      .mem_rdata(mem_rdata),
      .wr1_en(wr1_en), .wr1_idx(wr1_idx), .wr1_data(wr1_data),
      .wr2_en(wr2_en), .wr2_idx(wr2_idx), .wr2_data(wr2_data),
      .wb_en(wb_en), .wb_to_sp(wb_to_sp), .wb_idx(wb_idx), .wb_data(wb_data),
      .done(done), .busy(busy), .unsupported(unsupported),
      .misaligned(misaligned), .unpredictable(unpredictable)
   );

   task automatic chk(input bit ok, input string tag,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   // behavioural reference for one operation, compared on every falling edge
   task automatic run_op(input logic [31:0] iw, input logic [63:0] sp,
                         input int lat1, input int lat2, input string name);
      bit legal, mis, unp, post, wb;
      logic [4:0] t1, t2, n;
      longint off;
      logic [63:0] base, upd, a1, a2;
      logic [31:0] d1, d2;
      int kind;
      t1 = iw[4:0]; n = iw[9:5]; t2 = iw[14:10];
      legal = iw[31:30] == 2'b01 && iw[29:27] == 3'b101 && !iw[26] && iw[22] &&
              (iw[25:23] == 3'b001 || iw[25:23] == 3'b011 || iw[25:23] == 3'b010);
      post = iw[25:23] == 3'b001;
      wb = post || iw[25:23] == 3'b011;
      off = longint'(iw[21:15]);
      if (off >= 64) off -= 128;
      off = off * 4;
      base = (n == 5'd31) ? sp : rf_val(n);
      upd = base + 64'(off);
      a1 = post ? base : upd;
      a2 = a1 + 64'd4;
      mis = legal && n == 5'd31 && sp[3:0] != 4'd0;
      unp = legal && !mis && (t1 == t2 || (wb && n != 5'd31 && (t1 == n || t2 == n)));
      kind = !legal ? 1 : mis ? 2 : unp ? 3 : 0;

      @(negedge clk);
      instr = iw; sp_in = sp; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (kind != 0) begin
         chk(done == 1'b1, {name, " R10 fault done next cycle"}, 64'(done), 1);
         chk(unsupported == (kind == 1), {name, " R1 unsupported"}, 64'(unsupported), 64'(kind == 1));
         chk(misaligned == (kind == 2), {name, " R8 misaligned"}, 64'(misaligned), 64'(kind == 2));
         chk(unpredictable == (kind == 3), {name, " R9 unpredictable"}, 64'(unpredictable), 64'(kind == 3));
         chk(!mem_req && !wr1_en && !wr2_en && !wb_en, {name, " R8 R9 no access"},
             {60'd0, mem_req, wr1_en, wr2_en, wb_en}, 0);
      end else begin
         for (int k = 0; k < 2; k++) begin
            for (int c = 0; c <= (k == 0 ? lat1 : lat2); c++) begin
               chk(mem_req == 1'b1, {name, " R5 request held"}, 64'(mem_req), 1);
               chk(mem_addr == (k == 0 ? a1 : a2), {name, k == 0 ? " R4 first address" : " R5 second address"},
                   mem_addr, k == 0 ? a1 : a2);
               chk(!done && !wr1_en && busy, {name, " R10 busy during reads"},
                   {61'd0, done, wr1_en, busy}, 1);
               if (c == (k == 0 ? lat1 : lat2)) begin
                  mem_rvalid = 1'b1;
                  mem_rdata = mword(k == 0 ? a1 : a2);
               end
               @(negedge clk);
               mem_rvalid = 1'b0;
               mem_rdata = '0;
            end
         end
         d1 = mword(a1); d2 = mword(a2);
         chk(wr1_en && wr2_en && !mem_req, {name, " R6 write cycle"},
             {61'd0, wr1_en, wr2_en, mem_req}, 64'h6);
         chk(wr1_idx == t1 && wr2_idx == t2, {name, " R2 target fields"},
             {54'd0, wr1_idx, wr2_idx}, {54'd0, t1, t2});
         chk(wr1_data == {{32{d1[31]}}, d1}, {name, " R6 first word"}, wr1_data, {{32{d1[31]}}, d1});
         chk(wr2_data == {{32{d2[31]}}, d2}, {name, " R6 second word"}, wr2_data, {{32{d2[31]}}, d2});
         chk(wb_en == wb, {name, " R7 writeback enable"}, 64'(wb_en), 64'(wb));
         if (wb) begin
            chk(wb_data == upd && wb_idx == n, {name, " R7 writeback value"}, wb_data, upd);
            chk(wb_to_sp == (n == 5'd31), {name, " R3 writeback to sp"}, 64'(wb_to_sp), 64'(n == 5'd31));
         end
         @(negedge clk);
         chk(done && !wr1_en && !unsupported && !misaligned && !unpredictable,
             {name, " R10 done after writes"},
             {59'd0, done, wr1_en, unsupported, misaligned, unpredictable}, 64'h10);
      end
      @(negedge clk);
      chk(!done && !busy, {name, " R10 single done pulse"}, {62'd0, done, busy}, 0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=expired expected=finished");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!mem_req && !wr1_en && !wr2_en && !wb_en && !done && !busy &&
          !unsupported && !misaligned && !unpredictable, "R11 reset outputs",
          {55'd0, mem_req, wr1_en, wr2_en, wb_en, done, busy, unsupported, misaligned, unpredictable}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done, "R11 idle after reset", {62'd0, busy, done}, 0);

      run_op(mk(3'b010, 7'd4,    5'd4,  5'd1,  5'd3), 64'h0, 0, 0, "offs+16");
      run_op(mk(3'b010, 7'h40,   5'd6,  5'd5,  5'd2), 64'h0, 2, 1, "offs-256 R2");
      run_op(mk(3'b010, 7'd63,   5'd8,  5'd6,  5'd7), 64'h0, 1, 3, "offs+252 R2");
      run_op(mk(3'b010, 7'd1,    5'd11, 5'd10, 5'd10), 64'h0, 0, 1, "offs t1=base ok R9");
      run_op(mk(3'b011, 7'h7D,   5'd12, 5'd7,  5'd13), 64'h0, 0, 2, "pre-12 R4");
      run_op(mk(3'b001, 7'd10,   5'd14, 5'd9,  5'd15), 64'h0, 1, 0, "post+40 R4");
      run_op(mk(3'b011, 7'd2,    5'd1,  5'd31, 5'd2), 64'h0000_0000_0000_8000, 0, 0, "sp pre R3");
      run_op(mk(3'b001, 7'h7F,   5'd31, 5'd31, 5'd3), 64'h0000_0000_0001_0010 & ~64'hF, 2, 2, "sp post R3");
      run_op(mk(3'b010, 7'd0,    5'd2,  5'd31, 5'd1), 64'h0000_0000_0000_8000, 0, 0, "sp offs R3");
      run_op(mk(3'b010, 7'd0,    5'd2,  5'd31, 5'd1), 64'h0000_0000_0000_8004, 0, 0, "sp misaligned R8");
      run_op(mk(3'b011, 7'd4,    5'd2,  5'd31, 5'd1), 64'h0000_0000_0000_8008, 0, 0, "sp pre misaligned R8");
      run_op(mk(3'b000, 7'd1,    5'd2,  5'd3,  5'd1), 64'h0, 0, 0, "mode000 R1");
      run_op(mk(3'b111, 7'd1,    5'd2,  5'd3,  5'd1), 64'h0, 0, 0, "mode111 R1");
      run_op(mk(3'b010, 7'd1,    5'd2,  5'd3,  5'd1) & ~32'h0040_0000, 64'h0, 0, 0, "bit22 R1");
      run_op(mk(3'b010, 7'd1,    5'd2,  5'd3,  5'd1) ^ 32'h8000_0000, 64'h0, 0, 0, "opc R1");
      run_op(mk(3'b010, 7'd0,    5'd2,  5'd31, 5'd1) & ~32'h0040_0000, 64'h4, 0, 0, "bad+mis R1 R8");
      run_op(mk(3'b010, 7'd1,    5'd5,  5'd3,  5'd5), 64'h0, 0, 0, "t1=t2 R9");
      run_op(mk(3'b011, 7'd1,    5'd5,  5'd3,  5'd3), 64'h0, 0, 0, "pre t1=base R9");
      run_op(mk(3'b001, 7'd1,    5'd3,  5'd3,  5'd6), 64'h0, 0, 0, "post t2=base R9");
      run_op(mk(3'b001, 7'd3,    5'd4,  5'd31, 5'd31), 64'h0000_0000_0000_0100, 1, 1, "post sp t1=31 R9");
      run_op(mk(3'b010, 7'd4,    5'd4,  5'd1,  5'd3), 64'h0, 3, 3, "offs slow R5");

      finish_run();
   end
endmodule